// File: doc/BRIEF.md
# Pending List-Register Priority Selector

This block holds a small bank of virtual-interrupt list registers and picks, in one combinational pass, the pending entry with the best priority. It then decides whether that entry can preempt the code now running. The decision uses the virtual priority mask, the running priority, a group-priority mask and a flag that says a non-maskable interrupt is already active. The list registers are written through one write port and read back through one read port. The active-priority storage and the acknowledge sequencing live outside this block and supply their results as inputs.

Entries marked non-maskable (NMI) get three privileges. They beat ordinary entries of the same priority. They ignore the priority mask. They may preempt at an equal masked group priority, provided no NMI is active yet. When the NMI feature is configured out, the NMI bit is stripped from every list-register write.

Top module: `lr_prio_sel`

## Requirements
- R1: Each 64-bit list register is decoded with state in bits 63:62, group in bit 60, NMI flag in bit 59 and priority in bits 55:48. Only state 2'b01 (pending) is a candidate. Invalid (00), active (10) and pending-and-active (11) entries are never selected.
- R2: A candidate is skipped when its group's enable is clear (group bit 0 uses `grp0_en`, 1 uses `grp1_en`). With no candidate, `hit` is 0, `win_idx` is 0, `win_prio` is 8'hFF, `win_nmi` is 0 and `can_preempt` is 0.
- R3: The lowest priority value wins. Among candidates of equal priority and equal NMI flag, the lowest index wins.
- R4: At equal priority, an NMI candidate beats a non-NMI candidate. A numerically lower non-NMI priority still beats an NMI entry.
- R5: A non-NMI winner whose priority is greater than or equal to `vpmr` cannot preempt. An NMI winner ignores `vpmr`.
- R6: With `vif_en` clear, `can_preempt` is 0 whatever the list registers hold.
- R7: A non-NMI winner preempts only when (priority & `gprio_mask`) is strictly less than (`run_prio` & `gprio_mask`).
- R8: An NMI winner whose masked priority equals the masked running priority preempts when `nmi_active` is 0, and does not when `nmi_active` is 1.
- R9: With parameter NMI_SUPPORT = 0, bit 59 of every list-register write is stored as 0, and the entry behaves as non-NMI. With NMI_SUPPORT = 1, the bit is kept.
- R10: After reset, every list register reads 0 and `hit` is 0.
- R11: A write lands on the rising clock edge while `lr_we` is high. Its effect on the selection outputs and on `rd_data` is visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lr_we | input | 1 | List-register write enable |
| lr_waddr | input | IDX_W | Index of the list register to write |
| lr_wdata | input | 64 | Write data |
| rd_idx | input | IDX_W | Index of the list register to read |
| rd_data | output | 64 | Contents of list register `rd_idx` |
| grp0_en | input | 1 | Enable for group 0 entries |
| grp1_en | input | 1 | Enable for group 1 entries |
| vif_en | input | 1 | Global virtual interface enable |
| vpmr | input | 8 | Virtual priority mask |
| run_prio | input | 8 | Current running priority |
| gprio_mask | input | 8 | Group-priority mask applied to both sides of the preemption compare |
| nmi_active | input | 1 | An NMI is already active |
| hit | output | 1 | A candidate was found |
| win_idx | output | IDX_W | Index of the winning entry |
| win_prio | output | 8 | Priority of the winner (8'hFF when none) |
| win_nmi | output | 1 | Winner is an NMI |
| can_preempt | output | 1 | Winner may preempt |

## Verification
The bench builds two instances. The first uses four list registers with NMI support, which covers every selection tie, mask bypass and equal-priority NMI case across all index positions. The second uses two list registers with NMI support off. It shows that a write carrying the NMI bit reads back cleared, and that the stripped entry then obeys the priority mask like an ordinary entry.

// File: rtl/lr_prio_pkg.sv
package lr_prio_pkg;
  localparam int LR_W      = 64;
  localparam int PRIO_LSB  = 48;
  localparam int NMI_BIT   = 59;
  localparam int GRP_BIT   = 60;
  localparam int STATE_LSB = 62;

  typedef enum logic [1:0] {
    LR_INVALID     = 2'b00,
    LR_PENDING     = 2'b01,
    LR_ACTIVE      = 2'b10,
    LR_PEND_ACTIVE = 2'b11
  } lr_state_e;

  typedef struct packed {
    lr_state_e  state;
    logic       grp;
    logic       nmi;
    logic [7:0] prio;
  } lr_view_t;

  function automatic lr_view_t lr_decode(input logic [LR_W-1:0] raw);
    lr_view_t v;
    v.state = lr_state_e'(raw[STATE_LSB +: 2]);
    v.grp   = raw[GRP_BIT];
    v.nmi   = raw[NMI_BIT];
    v.prio  = raw[PRIO_LSB +: 8];
    return v;
  endfunction
endpackage

// File: rtl/lr_bank.sv
module lr_bank
  import lr_prio_pkg::*;
#(
  parameter int NUM_LR      = 4,
  parameter bit NMI_SUPPORT = 1'b1,
  localparam int IDX_W      = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [IDX_W-1:0]             waddr,
  input  logic [LR_W-1:0]              wdata,
  output logic [NUM_LR-1:0][LR_W-1:0]  regs
);
  logic [LR_W-1:0] wdata_clean;

  generate
    if (NMI_SUPPORT) begin : g_keep_nmi
      assign wdata_clean = wdata;
    end else begin : g_strip_nmi
      always_comb begin
        wdata_clean          = wdata;
        wdata_clean[NMI_BIT] = 1'b0;
      end
    end
  endgenerate

  for (genvar i = 0; i < NUM_LR; i++) begin : g_entry
    logic            en;
    logic [LR_W-1:0] d;
    assign en = we && (waddr == IDX_W'(i));
    assign d  = wdata_clean;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs[i] <= '0;
      else if (en) regs[i] <= d;
    end
  end
endmodule

// File: rtl/lr_scan.sv
module lr_scan
  import lr_prio_pkg::*;
#(
  parameter int NUM_LR = 4,
  localparam int IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
  input  logic [NUM_LR-1:0][LR_W-1:0] regs,
  input  logic                        grp0_en,
  input  logic                        grp1_en,
  output logic                        found,
  output logic [IDX_W-1:0]            idx,
  output logic [7:0]                  prio,
  output logic                        nmi
);
  lr_view_t v [NUM_LR];

  for (genvar i = 0; i < NUM_LR; i++) begin : g_dec
    assign v[i] = lr_decode(regs[i]);
  end

  always_comb begin
    found = 1'b0;
    idx   = '0;
    prio  = 8'hFF;
    nmi   = 1'b0;
    for (int i = 0; i < NUM_LR; i++) begin
      logic cand;
      logic better;
      cand   = (v[i].state == LR_PENDING) && (v[i].grp ? grp1_en : grp0_en);
      better = !found || (v[i].prio < prio) ||
               ((v[i].prio == prio) && v[i].nmi && !nmi);
      if (cand && better) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        prio  = v[i].prio;
        nmi   = v[i].nmi;
      end
    end
  end
endmodule

// File: rtl/lr_preempt.sv
module lr_preempt (
  input  logic       found,
  input  logic [7:0] prio,
  input  logic       nmi,
  input  logic       vif_en,
  input  logic [7:0] vpmr,
  input  logic [7:0] run_prio,
  input  logic [7:0] gprio_mask,
  input  logic       nmi_active,
  output logic       ok
);
  logic [7:0] cand_g;
  logic [7:0] run_g;
  logic       masked_out;

  assign cand_g     = prio & gprio_mask;
  assign run_g      = run_prio & gprio_mask;
  assign masked_out = !nmi && (prio >= vpmr);

  always_comb begin
    ok = 1'b0;
    if (vif_en && found && !masked_out) begin
      if (cand_g < run_g)                            ok = 1'b1;
      else if ((cand_g == run_g) && nmi && !nmi_active) ok = 1'b1;
    end
  end
endmodule

// File: rtl/lr_prio_sel.sv
module lr_prio_sel
  import lr_prio_pkg::*;
#(
  parameter int NUM_LR      = 4,
  parameter bit NMI_SUPPORT = 1'b1,
  localparam int IDX_W      = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lr_we,
  input  logic [IDX_W-1:0] lr_waddr,
  input  logic [63:0]      lr_wdata,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [63:0]      rd_data,
  input  logic             grp0_en,
  input  logic             grp1_en,
  input  logic             vif_en,
  input  logic [7:0]       vpmr,
  input  logic [7:0]       run_prio,
  input  logic [7:0]       gprio_mask,
  input  logic             nmi_active,
  output logic             hit,
  output logic [IDX_W-1:0] win_idx,
  output logic [7:0]       win_prio,
  output logic             win_nmi,
  output logic             can_preempt
);
  logic [NUM_LR-1:0][LR_W-1:0] regs;

  lr_bank #(.NUM_LR(NUM_LR), .NMI_SUPPORT(NMI_SUPPORT)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(lr_we), .waddr(lr_waddr),
    .wdata(lr_wdata), .regs(regs)
  );

  assign rd_data = regs[rd_idx];

  lr_scan #(.NUM_LR(NUM_LR)) u_scan (
    .regs(regs), .grp0_en(grp0_en), .grp1_en(grp1_en),
    .found(hit), .idx(win_idx), .prio(win_prio), .nmi(win_nmi)
  );

  lr_preempt u_pre (
    .found(hit), .prio(win_prio), .nmi(win_nmi), .vif_en(vif_en),
    .vpmr(vpmr), .run_prio(run_prio), .gprio_mask(gprio_mask),
    .nmi_active(nmi_active), .ok(can_preempt)
  );
endmodule

// File: rtl/lr_prio_sel_chk.sv
module lr_prio_sel_chk #(
  parameter int NMI_SUPPORT = 1,
  parameter int IDX_W       = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lr_we,
  input logic [IDX_W-1:0] lr_waddr,
  input logic [63:0]      lr_wdata,
  input logic [IDX_W-1:0] rd_idx,
  input logic [63:0]      rd_data,
  input logic             grp0_en,
  input logic             grp1_en,
  input logic             vif_en,
  input logic [7:0]       vpmr,
  input logic [7:0]       run_prio,
  input logic [7:0]       gprio_mask,
  input logic             nmi_active,
  input logic             hit,
  input logic [7:0]       win_prio,
  input logic             win_nmi,
  input logic             can_preempt
);
  a_r2_none_when_groups_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!grp0_en && !grp1_en) |-> (!hit && win_prio == 8'hFF && !can_preempt));

  a_r5_mask_blocks_ordinary: assert property (@(posedge clk) disable iff (!rst_n)
    (can_preempt && !win_nmi) |-> (win_prio < vpmr));

  a_r6_vif_gate: assert property (@(posedge clk) disable iff (!rst_n)
    can_preempt |-> (vif_en && hit));

  a_r7_never_lower_group: assert property (@(posedge clk) disable iff (!rst_n)
    can_preempt |-> ((win_prio & gprio_mask) <= (run_prio & gprio_mask)));

  a_r8_nmi_blocked_when_active: assert property (@(posedge clk) disable iff (!rst_n)
    (can_preempt && nmi_active) |-> ((win_prio & gprio_mask) < (run_prio & gprio_mask)));

  a_r9_nmi_bit_stripped: assert property (@(posedge clk) disable iff (!rst_n)
    (NMI_SUPPORT == 0) |-> (!rd_data[59] && !win_nmi));

  a_r11_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_we && lr_waddr == rd_idx) |=>
      (($past(rd_idx) != rd_idx) || (rd_data[55:48] == $past(lr_wdata[55:48]))));
endmodule

bind lr_prio_sel lr_prio_sel_chk #(.NMI_SUPPORT(int'(NMI_SUPPORT)), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lr_we(lr_we), .lr_waddr(lr_waddr), .lr_wdata(lr_wdata),
  .rd_idx(rd_idx), .rd_data(rd_data), .grp0_en(grp0_en), .grp1_en(grp1_en),
  .vif_en(vif_en), .vpmr(vpmr), .run_prio(run_prio), .gprio_mask(gprio_mask),
  .nmi_active(nmi_active), .hit(hit), .win_prio(win_prio), .win_nmi(win_nmi),
  .can_preempt(can_preempt)
);

// File: tb/lr_prio_sel_test.sv
module lr_prio_sel_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  int   n_run = 0;
  int   n_bad = 0;

  // instance A: four entries, NMI supported
  logic        we_a;
  logic [1:0]  wa_a, ri_a, idx_a;
  logic [63:0] wd_a, rd_a;
  logic        e0, e1, vif, nact;
  logic [7:0]  vpmr, rpr, gmask;
  logic        hit_a, nmi_a, pre_a;
  logic [7:0]  prio_a;

  lr_prio_sel #(.NUM_LR(4), .NMI_SUPPORT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .lr_we(we_a), .lr_waddr(wa_a), .lr_wdata(wd_a),
    .rd_idx(ri_a), .rd_data(rd_a), .grp0_en(e0), .grp1_en(e1), .vif_en(vif),
    .vpmr(vpmr), .run_prio(rpr), .gprio_mask(gmask), .nmi_active(nact),
    .hit(hit_a), .win_idx(idx_a), .win_prio(prio_a), .win_nmi(nmi_a),
    .can_preempt(pre_a)
  );

  // instance B: two entries, NMI support off
  logic        we_b;
  logic [0:0]  wa_b, ri_b, idx_b;
  logic [63:0] wd_b, rd_b;
  logic        hit_b, nmi_b, pre_b;
  logic [7:0]  prio_b;

  lr_prio_sel #(.NUM_LR(2), .NMI_SUPPORT(1'b0)) uut_nonmi (
    .clk(clk), .rst_n(rst_n), .lr_we(we_b), .lr_waddr(wa_b), .lr_wdata(wd_b),
    .rd_idx(ri_b), .rd_data(rd_b), .grp0_en(e0), .grp1_en(e1), .vif_en(vif),
    .vpmr(vpmr), .run_prio(rpr), .gprio_mask(gmask), .nmi_active(nact),
    .hit(hit_b), .win_idx(idx_b), .win_prio(prio_b), .win_nmi(nmi_b),
    .can_preempt(pre_b)
  );

  // entry nibble code: {state[1:0], grp, nmi} then 8-bit priority
  // layout: [88:41] lr3..lr0, [40:37] {g0en,g1en,vif,nmiact}, [36:29] vpmr,
  // [28:21] run prio, [20:13] mask, [12] hit, [11:10] idx, [9:2] prio, [1] nmi, [0] preempt
  localparam int NV = 17;
  localparam logic [88:0] VEC [NV] = '{
    {48'h000_000_000_000, 4'b1110, 8'hFF, 8'hFF, 8'hF8, 1'b0, 2'd0, 8'hFF, 1'b0, 1'b0}, // R2
    {48'h880_010_620_640, 4'b1110, 8'hFF, 8'hFF, 8'hF8, 1'b1, 2'd1, 8'h20, 1'b0, 1'b1}, // R1 R3
    {48'h730_730_630_630, 4'b1110, 8'hFF, 8'hFF, 8'hF8, 1'b1, 2'd2, 8'h30, 1'b1, 1'b1}, // R4
    {48'h650_000_650_000, 4'b1110, 8'hFF, 8'hFF, 8'hF8, 1'b1, 2'd1, 8'h50, 1'b0, 1'b1}, // R3
    {48'h000_000_000_640, 4'b1110, 8'h40, 8'hFF, 8'hF8, 1'b1, 2'd0, 8'h40, 1'b0, 1'b0}, // R5
    {48'h000_000_000_760, 4'b1110, 8'h40, 8'hFF, 8'hF8, 1'b1, 2'd0, 8'h60, 1'b1, 1'b1}, // R5
    {48'h000_000_000_640, 4'b1110, 8'hFF, 8'h40, 8'hF8, 1'b1, 2'd0, 8'h40, 1'b0, 1'b0}, // R7
    {48'h000_000_000_740, 4'b1110, 8'hFF, 8'h40, 8'hF8, 1'b1, 2'd0, 8'h40, 1'b1, 1'b1}, // R8
    {48'h000_000_000_740, 4'b1111, 8'hFF, 8'h40, 8'hF8, 1'b1, 2'd0, 8'h40, 1'b1, 1'b0}, // R8
    {48'h000_000_000_63F, 4'b1110, 8'hFF, 8'h40, 8'hF0, 1'b1, 2'd0, 8'h3F, 1'b0, 1'b1}, // R7
    {48'h000_000_000_644, 4'b1110, 8'hFF, 8'h40, 8'hF0, 1'b1, 2'd0, 8'h44, 1'b0, 1'b0}, // R7
    {48'h000_000_000_620, 4'b1100, 8'hFF, 8'hFF, 8'hF8, 1'b1, 2'd0, 8'h20, 1'b0, 1'b0}, // R6
    {48'h000_000_630_420, 4'b0110, 8'hFF, 8'hFF, 8'hF8, 1'b1, 2'd1, 8'h30, 1'b0, 1'b1}, // R2
    {48'h000_000_630_420, 4'b0010, 8'hFF, 8'hFF, 8'hF8, 1'b0, 2'd0, 8'hFF, 1'b0, 1'b0}, // R2
    {48'h000_000_620_440, 4'b1010, 8'hFF, 8'hFF, 8'hF8, 1'b1, 2'd0, 8'h40, 1'b0, 1'b1}, // R2
    {48'h000_000_650_E20, 4'b1110, 8'hFF, 8'hFF, 8'hF8, 1'b1, 2'd1, 8'h50, 1'b0, 1'b1}, // R1
    {48'h000_000_730_620, 4'b1110, 8'hFF, 8'hFF, 8'hF8, 1'b1, 2'd0, 8'h20, 1'b0, 1'b1}  // R4
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 12, 13, 14: return "R2";
      1, 15:         return "R1";
      3:             return "R3";
      2, 16:         return "R4";
      4, 5:          return "R5";
      6, 9, 10:      return "R7";
      7, 8:          return "R8";
      default:       return "R6";
    endcase
  endfunction

  function automatic logic [63:0] mk_lr(input logic [11:0] c, input int id);
    logic [63:0] w;
    w = 64'(id + 32);
    w[63:62] = c[11:10];
    w[60]    = c[9];
    w[59]    = c[8];
    w[55:48] = c[7:0];
    return w;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_a(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    we_a = 1'b1; wa_a = a; wd_a = d;
    @(negedge clk);
    we_a = 1'b0;
  endtask

  initial begin
    #150000;
    n_run++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    we_a = 0; wa_a = 0; wd_a = '0; ri_a = 0;
    we_b = 0; wa_b = 0; wd_b = '0; ri_b = 0;
    e0 = 1; e1 = 1; vif = 1; nact = 0; vpmr = 8'hFF; rpr = 8'hFF; gmask = 8'hF8;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    check("R10", {63'd0, hit_a}, 64'd0);
    ri_a = 2'd3; #1;
    check("R10", rd_a, 64'd0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      for (int k = 0; k < 4; k++) wr_a(2'(k), mk_lr(VEC[v][41 + 12*k +: 12], k));
      {e0, e1, vif, nact} = VEC[v][40:37];
      vpmr = VEC[v][36:29]; rpr = VEC[v][28:21]; gmask = VEC[v][20:13];
      #1;
      check(tag_of(v), {51'd0, hit_a, idx_a, prio_a, nmi_a, pre_a}, {51'd0, VEC[v][12:0]});
    end

    // R11: write takes effect at the edge, not before
    e0 = 1; e1 = 1; vif = 1; nact = 0; vpmr = 8'hFF; rpr = 8'hFF; gmask = 8'hF8;
    for (int k = 0; k < 4; k++) wr_a(2'(k), 64'd0);
    @(negedge clk);
    we_a = 1'b1; wa_a = 2'd2; wd_a = mk_lr(12'h610, 2); #1;
    check("R11", {63'd0, hit_a}, 64'd0);
    @(negedge clk);
    we_a = 1'b0; ri_a = 2'd2; #1;
    check("R11", {54'd0, hit_a, idx_a, prio_a}, {54'd0, 1'b1, 2'd2, 8'h10});
    check("R11", rd_a, mk_lr(12'h610, 2));

    // R9: NMI bit kept with support, stripped without
    wr_a(2'd1, mk_lr(12'h705, 1)); #1;
    ri_a = 2'd1; #1;
    check("R9", {63'd0, rd_a[59]}, 64'd1);
    @(negedge clk);
    we_b = 1'b1; wa_b = 1'b0; wd_b = mk_lr(12'h740, 0);
    @(negedge clk);
    we_b = 1'b0; ri_b = 1'b0; vpmr = 8'h40; #1;
    check("R9", {63'd0, rd_b[59]}, 64'd0);
    check("R9", {53'd0, hit_b, prio_b, nmi_b, pre_b}, {53'd0, 1'b1, 8'h40, 1'b0, 1'b0});

    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule